// File: doc/BRIEF.md
# Eight-Register Multi-Cycle 16-bit Processor Core

This core is a small multi-cycle processor. It executes 16-bit instructions from a 256-word memory. That memory sits outside the core and is reached through one synchronous port, which carries both instruction fetches and data accesses. There are eight 16-bit registers. Register 7 is the program counter and lives in the same register file as the others, so any instruction can read it, and a data result can overwrite it.

Each instruction takes two to four cycles. The address is held on the port for a fetch cycle and an execute cycle. Loads add two cycles: one to present the data address and one to capture the returned word. Stores add one cycle, in which the write strobe is high. Three condition flags (zero, negative, signed overflow) come from the arithmetic and logic operations and steer relative branches. A branch to its own address is the usual way to park the core at the end of a program.

Top module: `r8_core`

## Requirements
- R1: A synchronous reset clears all eight registers (so execution starts at address 0) and all three flags, and drives `mem_addr` to 0 and `mem_we` to 0.
- R2: An instruction word has its opcode in bits [15:12]. Every instruction keeps `mem_addr` at the PC for two cycles (fetch, then execute). The memory returns the word one cycle after it sees an address.
- R3: Opcodes 0 to 5 are ADD, SUB, AND, OR, XOR and NOT. They write the register named in [11:9]. The first operand is the register named in [8:6] and the second is the register named in [5:3]; NOT uses only [8:6].
- R4: ADD, SUB, AND, OR, XOR and NOT set Z when the result is zero and copy bit 15 into N. They set O on signed overflow for ADD and SUB, and clear O for the logic operations. Opcodes 12, 13 and 14 branch when Z, N or O is set, respectively.
- R5: Opcode 6 copies the register named in [8:6] into the one named in [11:9]. Opcode 10 writes the 9-bit immediate in [8:0], sign-extended to 16 bits, into the register named in [11:9]. Opcodes 7 and 11 change only the PC. Neither group alters the flags.
- R6: Opcode 8 loads into the register named in [11:9]. The address is the low 8 bits of the register named in [8:6], and `mem_addr` holds it for two cycles.
- R7: Opcode 9 stores. For exactly one cycle it drives `mem_we` high, with `mem_addr` set to the low 8 bits of the register named in [8:6] and `mem_wdata` set to the register named in [5:3].
- R8: Opcode 15 always branches. The target is the branch's own address plus the signed 12-bit offset in [11:0], taken modulo 256.
- R9: Any instruction that neither branches nor writes R7 advances the PC by one, and address 255 wraps to 0.
- R10: Reading R7 as an operand returns the executing instruction's address, zero-extended to 16 bits.
- R11: A data write to R7 (from the ALU, a move, a load or a load-immediate) sets the PC to the low 8 bits of the written value. This replaces the usual advance by one.
- R12: Opcode 15 with offset 0 fetches the same address again, indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 8 | Memory word address, registered |
| mem_wdata | output | 16 | Store data, registered |
| mem_we | output | 1 | Store strobe, registered |
| mem_rdata | input | 16 | Word read from memory, valid one cycle after the address |

## Verification
The data-path write and the PC advance can land in the same execute cycle whenever the destination field names R7. The register file then has to let the data value win over the increment. The bench provokes this collision with a load-immediate into R7 and with an ADD whose destination is R7. It judges the outcome by the address of the next fetch, which a behavioural instruction model predicts cycle by cycle. Register contents become visible only through stores, so every stored word is compared against the model's value and traced back to the requirement of the instruction that produced it.

// File: rtl/r8_pkg.sv
package r8_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'h0, OP_SUB   = 4'h1, OP_AND  = 4'h2, OP_OR   = 4'h3,
    OP_XOR   = 4'h4, OP_NOT   = 4'h5, OP_MOV  = 4'h6, OP_NOP  = 4'h7,
    OP_LOAD  = 4'h8, OP_STORE = 4'h9, OP_LDIMM = 4'hA, OP_RSVD = 4'hB,
    OP_BZERO = 4'hC, OP_BNEG  = 4'hD, OP_BOVF = 4'hE, OP_BALW  = 4'hF
  } opcode_t;

  typedef enum logic [2:0] {
    S_FETCH, S_EXEC, S_LDADDR, S_LDDATA, S_STORE
  } state_e;

endpackage

// File: rtl/r8_alu.sv
module r8_alu
  import r8_pkg::*;
#(
  parameter int DW = 16
) (
  input  opcode_t       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] res,
  output logic          zf,
  output logic          nf,
  output logic          of
);
  localparam int MSB = DW - 1;

  always_comb begin
    of = 1'b0;
    case (op)
      OP_ADD: begin
        res = a + b;
        of  = (a[MSB] == b[MSB]) && (res[MSB] != a[MSB]);
      end
      OP_SUB: begin
        res = a - b;
        of  = (a[MSB] != b[MSB]) && (res[MSB] != a[MSB]);
      end
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_NOT:  res = ~a;
      default: res = a;
    endcase
    zf = (res == '0);
    nf = res[MSB];
  end
endmodule

// File: rtl/r8_branch.sv
module r8_branch
  import r8_pkg::*;
#(
  parameter int AW   = 8,
  parameter int OFFW = 12
) (
  input  opcode_t         op,
  input  logic [AW-1:0]   pc,
  input  logic [OFFW-1:0] offset,
  input  logic            zf,
  input  logic            nf,
  input  logic            of,
  output logic            taken,
  output logic [AW-1:0]   target
);
  always_comb begin
    case (op)
      OP_BZERO: taken = zf;
      OP_BNEG:  taken = nf;
      OP_BOVF:  taken = of;
      OP_BALW:  taken = 1'b1;
      default:  taken = 1'b0;
    endcase
    target = AW'(OFFW'(pc) + offset);
  end
endmodule

// File: rtl/r8_regfile.sv
module r8_regfile #(
  parameter int DW   = 16,
  parameter int AW   = 8,
  parameter int NREG = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [$clog2(NREG)-1:0] rd_a_sel,
  input  logic [$clog2(NREG)-1:0] rd_b_sel,
  output logic [DW-1:0]           rd_a,
  output logic [DW-1:0]           rd_b,
  output logic [AW-1:0]           pc_q,
  input  logic                    wr_en,
  input  logic [$clog2(NREG)-1:0] wr_sel,
  input  logic [DW-1:0]           wr_data,
  input  logic                    pc_en,
  input  logic [AW-1:0]           pc_data
);
  localparam int PCR = NREG - 1;

  logic [DW-1:0] cells [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_cell
    logic [DW-1:0] q;
    if (i == PCR) begin : g_pc
      always_ff @(posedge clk) begin
        if (rst)                         q <= '0;
        else if (wr_en && wr_sel == i)   q <= DW'(wr_data[AW-1:0]);
        else if (pc_en)                  q <= DW'(pc_data);
      end
    end else begin : g_gp
      always_ff @(posedge clk) begin
        if (rst)                         q <= '0;
        else if (wr_en && wr_sel == i)   q <= wr_data;
      end
    end
    assign cells[i] = q;
  end

  assign rd_a = cells[rd_a_sel];
  assign rd_b = cells[rd_b_sel];
  assign pc_q = cells[PCR][AW-1:0];
endmodule

// File: rtl/r8_core.sv
module r8_core
  import r8_pkg::*;
#(
  parameter int DW   = 16,
  parameter int AW   = 8,
  parameter int NREG = 8
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata
);
  localparam int RSW  = $clog2(NREG);
  localparam int IMMW = 9;
  localparam int OFFW = 12;
  localparam logic [RSW-1:0] PCR = RSW'(NREG - 1);

  state_e         state;
  opcode_t        op;
  logic [RSW-1:0] f_dst, f_sa, f_sb, ld_dst;
  logic [DW-1:0]  ra_q, rb_q, alu_res;
  logic [AW-1:0]  pc_q, br_tgt, pc_next, fetch_addr;
  logic           alu_z, alu_n, alu_o, br_taken;
  logic           z_q, n_q, o_q;
  logic           wr_en, pc_en, flag_en;
  logic [RSW-1:0] wr_sel;
  logic [DW-1:0]  wr_data;

  assign op    = opcode_t'(mem_rdata[15:12]);
  assign f_dst = mem_rdata[11:9];
  assign f_sa  = mem_rdata[8:6];
  assign f_sb  = mem_rdata[5:3];

  r8_regfile #(.DW(DW), .AW(AW), .NREG(NREG)) u_rf (
    .clk(clk), .rst(rst),
    .rd_a_sel(f_sa), .rd_b_sel(f_sb), .rd_a(ra_q), .rd_b(rb_q), .pc_q(pc_q),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pc_en(pc_en), .pc_data(pc_next)
  );

  r8_alu #(.DW(DW)) u_alu (
    .op(op), .a(ra_q), .b(rb_q), .res(alu_res),
    .zf(alu_z), .nf(alu_n), .of(alu_o)
  );

  r8_branch #(.AW(AW), .OFFW(OFFW)) u_br (
    .op(op), .pc(pc_q), .offset(mem_rdata[OFFW-1:0]),
    .zf(z_q), .nf(n_q), .of(o_q),
    .taken(br_taken), .target(br_tgt)
  );

  // Execute-cycle control: which register is written and where the PC goes.
  always_comb begin
    wr_en   = 1'b0;
    wr_sel  = f_dst;
    wr_data = alu_res;
    pc_en   = 1'b0;
    pc_next = pc_q + AW'(1);
    flag_en = 1'b0;
    case (state)
      S_EXEC: begin
        case (op)
          OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOT: begin
            wr_en   = 1'b1;
            flag_en = 1'b1;
            pc_en   = 1'b1;
          end
          OP_MOV: begin
            wr_en   = 1'b1;
            wr_data = ra_q;
            pc_en   = 1'b1;
          end
          OP_LDIMM: begin
            wr_en   = 1'b1;
            wr_data = {{(DW-IMMW){mem_rdata[IMMW-1]}}, mem_rdata[IMMW-1:0]};
            pc_en   = 1'b1;
          end
          OP_LOAD, OP_STORE: ;
          OP_BZERO, OP_BNEG, OP_BOVF, OP_BALW: begin
            pc_en = 1'b1;
            if (br_taken) pc_next = br_tgt;
          end
          default: pc_en = 1'b1;
        endcase
      end
      S_LDDATA: begin
        wr_en   = 1'b1;
        wr_sel  = ld_dst;
        wr_data = mem_rdata;
        pc_en   = 1'b1;
      end
      S_STORE: pc_en = 1'b1;
      default: ;
    endcase
    fetch_addr = (wr_en && wr_sel == PCR) ? wr_data[AW-1:0] : pc_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_FETCH;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      ld_dst    <= '0;
      z_q       <= 1'b0;
      n_q       <= 1'b0;
      o_q       <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      if (flag_en) begin
        z_q <= alu_z;
        n_q <= alu_n;
        o_q <= alu_o;
      end
      case (state)
        S_FETCH: state <= S_EXEC;
        S_EXEC: begin
          if (op == OP_LOAD) begin
            mem_addr <= ra_q[AW-1:0];
            ld_dst   <= f_dst;
            state    <= S_LDADDR;
          end else if (op == OP_STORE) begin
            mem_addr  <= ra_q[AW-1:0];
            mem_wdata <= rb_q;
            mem_we    <= 1'b1;
            state     <= S_STORE;
          end else begin
            mem_addr <= fetch_addr;
            state    <= S_FETCH;
          end
        end
        S_LDADDR: state <= S_LDDATA;
        S_LDDATA, S_STORE: begin
          mem_addr <= fetch_addr;
          state    <= S_FETCH;
        end
        default: state <= S_FETCH;
      endcase
    end
  end
endmodule

// File: rtl/r8_core_checker.sv
module r8_core_checker
  import r8_pkg::*;
#(
  parameter int DW   = 16,
  parameter int AW   = 8,
  parameter int NREG = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic [AW-1:0]           mem_addr,
  input logic                    mem_we,
  input logic [DW-1:0]           mem_rdata,
  input state_e                  state,
  input logic [$clog2(NREG)-1:0] rd_sel,
  input logic [DW-1:0]           rd_val
);
  localparam int RSW = $clog2(NREG);

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R1: outputs cleared while reset is held
  always @(negedge clk)
    if (rst_q === 1'b1 && rst === 1'b1)
      a_reset_clear_r1: assert (mem_addr == '0 && !mem_we);

  p_fetch_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (state == S_FETCH) |=> (state == S_EXEC && $stable(mem_addr)));

  p_load_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (state == S_LDADDR) |=> (state == S_LDDATA && $stable(mem_addr)));

  p_we_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  p_we_store_only_r7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (state == S_STORE));

  p_noop_advance_r9: assert property (@(posedge clk) disable iff (rst)
    (state == S_EXEC && (mem_rdata[15:12] == 4'h7 || mem_rdata[15:12] == 4'hB))
    |=> (mem_addr == AW'($past(mem_addr) + AW'(1))));

  p_pc_zero_ext_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == RSW'(NREG - 1)) |-> (rd_val[DW-1:AW] == '0));

  p_self_branch_r12: assert property (@(posedge clk) disable iff (rst)
    (state == S_EXEC && mem_rdata == 16'hF000) |=> (mem_addr == $past(mem_addr)));
endmodule

bind r8_core r8_core_checker #(.DW(DW), .AW(AW), .NREG(NREG)) u_chk (
  .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
  .mem_rdata(mem_rdata), .state(state), .rd_sel(f_sa), .rd_val(ra_q)
);

// File: tb/r8_core_test.sv
module r8_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic [15:0] mem_rdata;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  r8_core uut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata)
  );

  // Memory seen by the core
  logic [15:0] mem [256];
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  // Behavioural instruction model
  typedef struct {
    logic [7:0]  a;
    logic        w;
    logic [15:0] d;
    string       t;
    string       dt;
  } exp_t;

  exp_t        expq[$];
  logic [15:0] rr [8];
  string       lw [8];
  logic [15:0] rmem [256];
  bit          fz, fn, fo;
  bit          skip_if = 1;
  string       fetch_tag = "R1";

  task automatic put(input int ad, input logic [15:0] w);
    mem[ad]  = w;
    rmem[ad] = w;
  endtask

  function automatic logic [15:0] e3(input int op, input int d, input int a, input int b);
    return {4'(op), 3'(d), 3'(a), 3'(b), 3'b000};
  endfunction
  function automatic logic [15:0] eli(input int d, input int imm);
    return {4'hA, 3'(d), 9'(imm)};
  endfunction
  function automatic logic [15:0] ebr(input int op, input int off);
    return {4'(op), 12'(off)};
  endfunction

  task automatic push(input logic [7:0] a, input logic w, input logic [15:0] d,
                      input string t, input string dt);
    exp_t e;
    e.a = a; e.w = w; e.d = d; e.t = t; e.dt = dt;
    expq.push_back(e);
  endtask

  task automatic step();
    logic [7:0]  p, nxt;
    logic [15:0] ins, va, vb, res;
    int          op, d, a, b, sv;
    bit          wr;
    string       tg, nt;
    p   = rr[7][7:0];
    ins = rmem[p];
    op  = int'(ins[15:12]);
    d   = int'(ins[11:9]);
    a   = int'(ins[8:6]);
    b   = int'(ins[5:3]);
    va  = (a == 7) ? {8'h00, p} : rr[a];
    vb  = (b == 7) ? {8'h00, p} : rr[b];
    nxt = p + 8'd1;
    nt  = "R9";
    tg  = "R5";
    wr  = 0;
    res = '0;
    if (!skip_if) push(p, 1'b0, '0, fetch_tag, "");
    skip_if = 0;
    push(p, 1'b0, '0, "R2", "");
    case (op)
      0, 1: begin
        if (op == 0) sv = int'($signed(va)) + int'($signed(vb));
        else         sv = int'($signed(va)) - int'($signed(vb));
        res = sv[15:0];
        fo  = (sv > 32767) || (sv < -32768);
        fz  = (res == 0);
        fn  = res[15];
        wr  = 1; tg = "R3";
      end
      2, 3, 4, 5: begin
        if (op == 2)      res = va & vb;
        else if (op == 3) res = va | vb;
        else if (op == 4) res = va ^ vb;
        else              res = ~va;
        fo = 0; fz = (res == 0); fn = res[15];
        wr = 1; tg = "R3";
      end
      6:  begin res = va; wr = 1; tg = "R5"; end
      10: begin res = {{7{ins[8]}}, ins[8:0]}; wr = 1; tg = "R5"; end
      8: begin
        push(va[7:0], 1'b0, '0, "R6", "");
        push(va[7:0], 1'b0, '0, "R6", "");
        res = rmem[va[7:0]]; wr = 1; tg = "R6";
      end
      9: begin
        push(va[7:0], 1'b1, vb, "R7", (b == 7) ? "R10" : lw[b]);
        rmem[va[7:0]] = vb;
      end
      12, 13, 14, 15: begin
        bit tk;
        tk = (op == 15) || (op == 12 && fz) || (op == 13 && fn) || (op == 14 && fo);
        if (tk) nxt = p + ins[7:0];
        if (op != 15)              nt = "R4";
        else if (ins[11:0] == 0)   nt = "R12";
        else                       nt = "R8";
      end
      default: ;
    endcase
    if (wr) begin
      if (d == 7) begin nxt = res[7:0]; nt = "R11"; end
      else begin rr[d] = res; lw[d] = tg; end
    end
    rr[7]     = {8'h00, nxt};
    fetch_tag = nt;
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic build();
    for (int i = 0; i < 256; i++) put(i, 16'h7000);
    put(0,  ebr(12, 2));          // taken only after the wrap, with Z set
    put(1,  ebr(15, 15));
    put(2,  ebr(15, 0));
    put(16, eli(1, 5));
    put(17, eli(2, -3));
    put(18, eli(4, 192));
    put(19, eli(6, 1));
    put(20, e3(0, 3, 1, 2));
    put(21, e3(9, 0, 4, 3));
    put(22, e3(0, 4, 4, 6));
    put(23, e3(1, 3, 2, 1));
    put(24, ebr(13, 2));
    put(25, eli(3, 0));
    put(26, e3(9, 0, 4, 3));
    put(27, e3(0, 4, 4, 6));
    put(28, ebr(12, 5));
    put(29, eli(5, 255));
    for (int i = 30; i <= 37; i++) put(i, e3(0, 5, 5, 5));
    put(38, ebr(14, 2));
    put(39, eli(5, 0));
    put(40, e3(9, 0, 4, 5));
    put(41, e3(0, 4, 4, 6));
    put(42, e3(2, 3, 5, 1));
    put(43, ebr(14, 3));
    put(44, ebr(12, 2));
    put(45, eli(3, 1));
    put(46, e3(3, 3, 1, 2));
    put(47, e3(4, 3, 3, 2));
    put(48, e3(5, 3, 3, 0));
    put(49, e3(6, 0, 3, 0));
    put(50, e3(9, 0, 4, 0));
    put(51, e3(0, 4, 4, 6));
    put(52, eli(5, 192));
    put(53, e3(8, 0, 5, 0));
    put(54, e3(9, 0, 4, 0));
    put(55, e3(0, 4, 4, 6));
    put(56, e3(6, 0, 7, 0));
    put(57, e3(9, 0, 4, 0));
    put(58, e3(0, 4, 4, 6));
    put(59, e3(9, 0, 4, 7));
    put(60, e3(0, 4, 4, 6));
    put(61, eli(7, 70));
    put(70, eli(5, -256));
    for (int i = 71; i <= 77; i++) put(i, e3(0, 5, 5, 5));
    put(78, e3(1, 3, 5, 6));
    put(79, ebr(14, 2));
    put(80, eli(3, 9));
    put(81, e3(9, 0, 4, 3));
    put(82, e3(0, 4, 4, 6));
    put(83, ebr(15, 3));
    put(84, ebr(15, 4));
    put(86, ebr(15, -2));
    put(88, eli(0, 247));
    put(89, e3(0, 7, 0, 1));
    put(252, e3(4, 0, 0, 0));
    put(253, e3(6, 1, 0, 0));
    put(254, eli(2, 7));
    put(255, 16'hB000);
    for (int i = 0; i < 8; i++) begin rr[i] = '0; lw[i] = "R1"; end
    fz = 0; fn = 0; fo = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    build();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(mem_addr == 8'h00, "R1", "reset mem_addr", {8'h00, mem_addr}, 16'h0000);
    chk(mem_we == 1'b0, "R1", "reset mem_we", {15'h0, mem_we}, 16'h0000);
    rst = 1'b0;
    for (int cyc = 0; cyc < 700; cyc++) begin
      exp_t e;
      @(negedge clk);
      if (expq.size() == 0) step();
      e = expq.pop_front();
      chk(mem_addr == e.a, e.t, "mem_addr", {8'h00, mem_addr}, {8'h00, e.a});
      chk(mem_we == e.w, e.t, "mem_we", {15'h0, mem_we}, {15'h0, e.w});
      if (e.w) chk(mem_wdata == e.d, e.dt, "mem_wdata", mem_wdata, e.d);
    end
    // R7: final memory image matches the model's stores
    for (int i = 0; i < 256; i++)
      chk(mem[i] === rmem[i], "R7", "memory word", mem[i], rmem[i]);
    finish_run();
  end

  initial begin
    #(4 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog expired, actual=running expected=finished");
    finish_run();
  end
endmodule